// File: doc/BRIEF.md
# Converter Nap Power Sequencer

This block sits in the digital section of a sampling converter. It decides when the converter may start a conversion and when it may rest in a low-power nap. One combined start/select pin drives it. A rising level on the pin asks for a conversion. A pin held high when a conversion finishes sends the block into nap, if nap is enabled. A falling level on the pin wakes the block. After waking, a guard timer must expire before the next start is honoured. The conversion engine is stood in for by a busy counter of fixed length.

The nap enable lives in a guarded power-control register. Writes to it take effect only after a key value has been written to a separate key address. Once a set number of control writes has been accepted, the guard closes again. A synchronous reset also closes it. The pin is asynchronous to the clock and passes through a two-stage synchronizer before its edges are detected.

Top module: `nap_pwr_seq`

## Requirements
- R1: A write of 0x69 to address 0x5 opens the guard, so that `unlocked` reads 1 after that clock edge. A different value at that address leaves the guard closed.
- R2: While the guard is closed, a write to the control address 0x4 leaves `ctrl_q` unchanged.
- R3: While the guard is open, a write to address 0x4 loads `ctrl_q`. After RELOCK_WRITES accepted writes (default 2), the guard closes again. A synchronous reset clears `ctrl_q` to 0 and closes the guard.
- R4: Nap enable is bit 0 of `ctrl_q`. When it is 1 and the synchronized pin is high as a conversion ends, `state_q` becomes 2 (nap). A conversion occupies `state_q` = 1 for CONV_CYCLES clocks.
- R5: When nap enable is 0, every conversion ends in `state_q` = 0 (acquire), whatever the pin level, and the block never enters nap.
- R6: The block stays in nap while the pin stays high. A falling pin level moves it to `state_q` = 3 (waking).
- R7: Waking lasts WAKE_CYCLES clocks and then returns to acquire. At that moment `wake_done` goes high, and it stays high until the next conversion starts.
- R8: A rising pin level while waking or converting pulses `start_err` for one clock and starts nothing. The request is not kept for later.
- R9: A rising pin level in acquire starts a conversion three clock edges after the pin changes: two synchronizer stages plus the state register. `start_ok` is 1 exactly when `state_q` is 0.
- R10: After reset, `state_q` is 0, `start_ok` is 1, and `unlocked`, `wake_done` and `start_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| cs_pin | input | 1 | Asynchronous combined start/select pin |
| ctrl_q | output | DATA_W | Power-control register contents |
| unlocked | output | 1 | Guard open, control writes accepted |
| state_q | output | 2 | 0 acquire, 1 converting, 2 nap, 3 waking |
| start_ok | output | 1 | A new conversion may start |
| wake_done | output | 1 | Wake guard has expired since the last nap |
| start_err | output | 1 | One-clock pulse on a rejected start |

## Verification
The hardest situation to reach is a start request landing near the end of the wake window. The pin's fall and its rise both pass through the synchronizer, so the cycle that matters is several clocks away from the pin change. The bench enters nap and drops the pin. It then raises the pin again after every delay from one clock to two clocks past the wake length. For each delay it computes whether the request falls inside the window, in which case it is rejected and not kept, or after it, in which case a conversion starts and ends in a fresh nap. A further case raises a second request in the middle of a conversion.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_CONV = 2'd1,
    ST_NAP  = 2'd2,
    ST_WAKE = 2'd3
  } nps_state_e;
endpackage

// File: rtl/nps_sync.sv
module nps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/nps_regs.sv
module nps_regs #(
  parameter int          ADDR_W        = 4,
  parameter int          DATA_W        = 8,
  parameter int          KEY_ADDR      = 5,
  parameter int          KEY_VAL       = 'h69,
  parameter int          CTRL_ADDR     = 4,
  parameter int          RELOCK_WRITES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl,
  output logic              open_q
);
  localparam int BW = $clog2(RELOCK_WRITES + 1);
  localparam logic [ADDR_W-1:0] KA = ADDR_W'(KEY_ADDR);
  localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);
  localparam logic [DATA_W-1:0] KV = DATA_W'(KEY_VAL);

  logic [BW-1:0] budget;
  logic          key_hit, ctrl_hit;

  assign key_hit  = wr_en && (wr_addr == KA) && (wr_data == KV);
  assign ctrl_hit = wr_en && (wr_addr == CA) && open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      open_q <= 1'b0;
      budget <= '0;
    end else if (key_hit) begin
      open_q <= 1'b1;
      budget <= BW'(RELOCK_WRITES);
    end else if (ctrl_hit) begin
      ctrl   <= wr_data;
      budget <= budget - 1'b1;
      if (budget == BW'(1)) open_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nps_fsm.sv
module nps_fsm
  import nps_pkg::*;
#(
  parameter int CONV_CYCLES = 16,
  parameter int WAKE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       nap_en,
  input  logic       lvl,
  input  logic       rise,
  input  logic       fall,
  output nps_state_e state,
  output logic       wake_done,
  output logic       start_err
);
  localparam int MAXC = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_ACQ;
      cnt       <= '0;
      wake_done <= 1'b0;
      start_err <= 1'b0;
    end else begin
      start_err <= 1'b0;
      unique case (state)
        ST_ACQ: begin
          if (rise) begin
            state     <= ST_CONV;
            cnt       <= CW'(CONV_CYCLES - 1);
            wake_done <= 1'b0;
          end
        end
        ST_CONV: begin
          if (rise) start_err <= 1'b1;
          if (cnt == '0) state <= (nap_en && lvl) ? ST_NAP : ST_ACQ;
          else           cnt   <= cnt - 1'b1;
        end
        ST_NAP: begin
          if (fall) begin
            state <= ST_WAKE;
            cnt   <= CW'(WAKE_CYCLES - 1);
          end
        end
        ST_WAKE: begin
          if (rise) start_err <= 1'b1;
          if (cnt == '0) begin
            state     <= ST_ACQ;
            wake_done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_ACQ;
      endcase
    end
  end
endmodule

// File: rtl/nap_pwr_seq.sv
module nap_pwr_seq
  import nps_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 8,
  parameter int KEY_ADDR      = 5,
  parameter int KEY_VAL       = 'h69,
  parameter int CTRL_ADDR     = 4,
  parameter int NAP_BIT       = 0,
  parameter int RELOCK_WRITES = 2,
  parameter int CONV_CYCLES   = 16,
  parameter int WAKE_CYCLES   = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cs_pin,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              unlocked,
  output logic [1:0]        state_q,
  output logic              start_ok,
  output logic              wake_done,
  output logic              start_err
);
  logic       cs_lvl, cs_rise, cs_fall;
  logic       nap_en;
  nps_state_e st;

  nps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .pin (cs_pin),
    .lvl (cs_lvl), .rise (cs_rise), .fall (cs_fall)
  );

  nps_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR), .KEY_VAL(KEY_VAL),
    .CTRL_ADDR(CTRL_ADDR), .RELOCK_WRITES(RELOCK_WRITES)
  ) u_regs (
    .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (wr_data), .ctrl (ctrl_q), .open_q (unlocked)
  );

  assign nap_en = ctrl_q[NAP_BIT];

  nps_fsm #(.CONV_CYCLES(CONV_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
    .clk (clk), .rst (rst), .nap_en (nap_en), .lvl (cs_lvl),
    .rise (cs_rise), .fall (cs_fall), .state (st),
    .wake_done (wake_done), .start_err (start_err)
  );

  assign state_q  = st;
  assign start_ok = (st == ST_ACQ);
endmodule

// File: rtl/nps_chk.sv
module nps_chk #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int KEY_ADDR  = 5,
  parameter int KEY_VAL   = 'h69,
  parameter int CTRL_ADDR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              unlocked,
  input logic [1:0]        state_q,
  input logic              start_ok,
  input logic              wake_done,
  input logic              start_err,
  input logic              cs_lvl,
  input logic              nap_en
);
  a_r1_key_opens: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(KEY_ADDR) && wr_data == DATA_W'(KEY_VAL)) |=> unlocked);

  a_r2_locked_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked && wr_addr == ADDR_W'(CTRL_ADDR)) |=> $stable(ctrl_q));

  a_r5_nap_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'd1) ##1 (state_q == 2'd2) |-> $past(nap_en));

  a_r6_nap_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'd2 && cs_lvl) |=> (state_q == 2'd2));

  a_r6_nap_exit_to_wake: assert property (@(posedge clk) disable iff (rst)
    (state_q == 2'd2) ##1 (state_q != 2'd2) |-> (state_q == 2'd3));

  a_r7_done_in_acq: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_done) |-> (state_q == 2'd0));

  a_r8_err_no_start: assert property (@(posedge clk) disable iff (rst)
    start_err |-> !(state_q == 2'd1 && $past(state_q) != 2'd1));

  a_r9_ok_only_acq: assert property (@(posedge clk) disable iff (rst)
    start_ok |-> (state_q == 2'd0));
endmodule

bind nap_pwr_seq nps_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
  .KEY_VAL(KEY_VAL), .CTRL_ADDR(CTRL_ADDR)
) u_nps_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ctrl_q(ctrl_q), .unlocked(unlocked), .state_q(state_q), .start_ok(start_ok),
  .wake_done(wake_done), .start_err(start_err), .cs_lvl(cs_lvl), .nap_en(nap_en)
);

// File: tb/test_nap_pwr_seq.sv
`timescale 1ns/1ps
module test_nap_pwr_seq;
  localparam int C  = 6;
  localparam int W  = 3;
  localparam int UW = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       cs_pin = 1'b0;
  logic [7:0] ctrl_q;
  logic       unlocked, start_ok, wake_done, start_err;
  logic [1:0] state_q;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  nap_pwr_seq #(
    .RELOCK_WRITES(UW), .CONV_CYCLES(C), .WAKE_CYCLES(W)
  ) i_nap_pwr_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cs_pin(cs_pin), .ctrl_q(ctrl_q), .unlocked(unlocked), .state_q(state_q),
    .start_ok(start_ok), .wake_done(wake_done), .start_err(start_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_nap;
    cs_pin = 1'b0;
    tick(4);
    cs_pin = 1'b1;
    tick(3 + C);
    chk("R4 nap after conversion with pin high", state_q, 2);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    // R10 reset state
    chk("R10 state", state_q, 0);
    chk("R10 start_ok", start_ok, 1);
    chk("R10 unlocked", unlocked, 0);
    chk("R10 wake_done", wake_done, 0);
    chk("R10 start_err", start_err, 0);
    chk("R10 ctrl", ctrl_q, 0);

    // R9 + R5: normal-mode conversion with pin held high
    cs_pin = 1'b1;
    tick(2);
    chk("R9 not yet started", state_q, 0);
    tick(1);
    chk("R9 started after 3 edges", state_q, 1);
    chk("R9 start_ok low", start_ok, 0);
    tick(C - 1);
    chk("R4 conversion length", state_q, 1);
    tick(1);
    chk("R5 no nap when disabled", state_q, 0);
    tick(8);
    chk("R5 stays in acquire", state_q, 0);
    cs_pin = 1'b0;
    tick(4);

    // R2 writes ignored while locked; wrong key keeps guard shut
    wr(4'h4, 8'h01);
    chk("R2 locked write ignored", ctrl_q, 0);
    wr(4'h5, 8'h68);
    chk("R1 wrong key", unlocked, 0);
    wr(4'h4, 8'h01);
    chk("R2 still ignored", ctrl_q, 0);
    wr(4'h5, 8'h69);
    chk("R1 key opens", unlocked, 1);

    // R3 accepted writes then relock
    for (int i = 0; i < UW; i++) begin
      logic [7:0] v;
      v = (i == UW - 1) ? 8'h01 : 8'h5A + 8'(i);
      wr(4'h4, v);
      chk("R3 write loads", ctrl_q, v);
      chk("R3 guard state", unlocked, (i == UW - 1) ? 0 : 1);
    end
    wr(4'h4, 8'hFE);
    chk("R3 write after relock ignored", ctrl_q, 8'h01);

    // R4 + R6 nap entry and hold
    enter_nap();
    tick(10);
    chk("R6 nap held while pin high", state_q, 2);

    // R6/R7/R8 sweep of re-raise delay after wake-up
    for (int d = 1; d <= W + 2; d++) begin
      if (state_q != 2'd2) enter_nap();
      cs_pin = 1'b0;
      for (int k = 1; k <= d + 4 + C; k++) begin
        @(negedge clk);
        if (k == 3 && d >= 1) chk("R6 fall leads to wake", state_q, 3);
        if (k == 3 + W && d + 3 > 3 + W) begin
          chk("R7 wake ends in acquire", state_q, 0);
          chk("R7 wake_done high", wake_done, 1);
        end
        if (d <= W && k == d + 3) begin
          chk("R8 rejected start flagged", start_err, 1);
          chk("R8 no conversion", state_q == 2'd1, 0);
        end
        if (d <= W && k == d + 4) chk("R8 flag is one pulse", start_err, 0);
        if (d <= W && k == d + 4 + C) begin
          chk("R8 request not kept", state_q, 0);
          chk("R7 wake_done held", wake_done, 1);
        end
        if (d > W && k == d + 3) begin
          chk("R9 start after wake", state_q, 1);
          chk("R7 wake_done cleared on start", wake_done, 0);
          chk("R9 no error", start_err, 0);
        end
        if (d > W && k == d + 3 + C) chk("R4 nap again", state_q, 2);
        if (k == d) cs_pin = 1'b1;
      end
    end

    // R8 second request during a conversion
    cs_pin = 1'b0;
    tick(4 + W + 2);
    chk("R7 back in acquire", state_q, 0);
    cs_pin = 1'b1;
    tick(3);
    chk("R9 conversion started", state_q, 1);
    cs_pin = 1'b0;
    tick(1);
    cs_pin = 1'b1;
    tick(3);
    chk("R8 error during conversion", start_err, 1);
    chk("R8 conversion continues", state_q, 1);
    tick(C - 4);
    chk("R4 conversion ends in nap", state_q, 2);

    // R3 reset closes guard and clears register
    cs_pin = 1'b0;
    wr(4'h5, 8'h69);
    chk("R1 key opens again", unlocked, 1);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    chk("R3 reset relocks", unlocked, 0);
    chk("R3 reset clears ctrl", ctrl_q, 0);
    wr(4'h4, 8'h01);
    chk("R2 ignored after reset", ctrl_q, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule